// File: doc/BRIEF.md
# Signed serial-parallel multiplier

This block multiplies a two's-complement multiplicand, presented as a parallel word, by a two's-complement multiplier that arrives one bit per clock with the least significant bit first. It returns the product one bit per clock, also least significant bit first. A single-cycle `load` pulse starts a product. The block captures the multiplicand and takes the first multiplier bit in that same cycle. The next MPLR_W-1 cycles supply the remaining multiplier bits.

Internally, the multiplicand is stored as a magnitude together with a sign flag. One column cell per multiplicand bit forms the partial product with an AND gate and adds it to the running sum held in the cell above it. Each cell keeps its own carry in a flip-flop. When the supplied multiplier bits run out, the last one is repeated. The lowest column's sum passes through an on-the-fly two's-complement negator whenever the multiplicand was negative. A registered output bit follows the negator.

A complete product of MCAND_W+MPLR_W bits leaves the block over that many cycles. After the last of those bits, the output continues with the correct sign extension until the next `load`.

Top module: `spm_signed_mult`

## Requirements
- R1: After reset, and until the first `load`, `prod_bit` is 0 whatever `mcand` and `mplr_bit` do.
- R2: In the cycle `load` is high, the block captures `mcand` as A and takes `mplr_bit` as multiplier bit 0. Bit k of the product is on `prod_bit` after the (k+1)-th rising edge counted from, and including, the edge that samples `load`.
- R3: Over MCAND_W+MPLR_W cycles, `prod_bit` delivers the full two's-complement product A*B, LSB first. A and B are both read as signed.
- R4: Multiplier bits are read from `mplr_bit` only in the MPLR_W cycles that begin with the `load` cycle. After that, the input is ignored, and the last bit taken (the sign bit) is repeated internally.
- R5: A negative multiplicand, including the most negative value, gives the correct product. Negation is applied to the result, so the product is correct for every sign combination.
- R6: Product bit 0 equals the AND of mcand bit 0 and the multiplier bit given with `load`.
- R7: After product bit MCAND_W+MPLR_W-1, `prod_bit` keeps showing the sign extension of the product until the next `load`.
- R8: A `load` during a product abandons it. All carries, partial sums and the negator state are cleared, and the new product is exact from its first bit.
- R9: Changes on `mcand` in cycles other than the `load` cycle have no effect on the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Start pulse: captures the multiplicand and multiplier bit 0 |
| mcand | input | MCAND_W | Parallel two's-complement multiplicand |
| mplr_bit | input | 1 | Serial multiplier bit, LSB first |
| prod_bit | output | 1 | Serial product bit, LSB first |

## Verification
The products cover every sign combination:
- Small positive operands check the adder chain and carry drain on their own.
- A negative multiplicand or negative multiplier separates the result negator from the multiplier sign extension.
- The extreme pairs (most negative times most negative, most negative times maximum) expose magnitude overflow and missing carry propagation in the top bits.
- Zero operands show that stale state does not leak into the output.

Some runs drive random values on `mcand` after the load cycle, and on `mplr_bit` after the multiplier bits are exhausted, so that any unintended sampling shows up. A load issued mid-product checks that the old carries are flushed.

// File: rtl/spm_pkg.sv
// Package: shared types and helpers for the serial-parallel multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package spm_pkg;

    // Result of one full-adder evaluation.
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_t;

    // Full-adder evaluation of three one-bit operands.
    function automatic fa_t full_add(input logic a, input logic b, input logic c);
        fa_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/spm_magnitude.sv
// Module: spm_magnitude
// Converts the two's-complement multiplicand to an unsigned magnitude and a
// sign flag. Both are registered on load. In the load cycle itself the
// outputs bypass the registers, so the first column step can use the value
// being captured.
// Assumes: WIDTH >= 2. The magnitude of the most negative value is
// 2**(WIDTH-1), which fits in WIDTH unsigned bits.
module spm_magnitude #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] mag_use,
    output logic             neg_use
);
    logic [WIDTH-1:0] mag_d;
    logic [WIDTH-1:0] mag_q;
    logic             neg_q;

    // Absolute value of the incoming word.
    always_comb begin
        mag_d = value[WIDTH-1] ? (~value + WIDTH'(1)) : value;
    end

    // Capture magnitude and sign when a product starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            mag_q <= mag_d;
            neg_q <= value[WIDTH-1];
        end
    end

    // Bypass: the load cycle works on the fresh value.
    always_comb begin
        mag_use = load ? mag_d : mag_q;
        neg_use = load ? value[WIDTH-1] : neg_q;
    end

    // R5: the magnitude MSB can only be set by the most negative input.
    assert_mag_msb_only_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mag_q[WIDTH-1] |-> (neg_q && (mag_q[WIDTH-2:0] == '0)));

endmodule

// File: rtl/spm_mplr_feed.sv
// Module: spm_mplr_feed
// Supplies the multiplier bit for every cycle. In the load cycle and the
// WIDTH-1 cycles after it, the bit comes from the serial input. After that,
// the last bit taken is repeated, which sign-extends the multiplier.
// Assumes: load is a single-cycle pulse. A new load restarts the count.
module spm_mplr_feed #(
    parameter int WIDTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bit_in,
    output logic bit_use
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WIDTH);

    logic [CNT_W-1:0] cnt_q;
    logic             ext_q;
    logic             taking;

    // Choose between the live input and the held sign bit.
    always_comb begin
        taking  = load || (cnt_q < CNT_END);
        bit_use = taking ? bit_in : ext_q;
    end

    // Count consumed bits (saturating) and hold the latest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_END;
            ext_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= CNT_W'(1);
            end else if (cnt_q < CNT_END) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (taking) begin
                ext_q <= bit_in;
            end
        end
    end

    // R4: once the stream is exhausted, the repeated bit never changes.
    assert_ext_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt_q == CNT_END)) |=> $stable(ext_q));

endmodule

// File: rtl/spm_column_cell.sv
// Module: spm_column_cell
// One column of the carry-save accumulator. It adds its partial product, the
// sum held by the column above, and its own stored carry. The carry is
// always registered. The sum is registered only when a lower column reads
// it (HOLD_SUM=1). Column 0 hands its sum straight to the output path.
// Assumes: clr is asserted in the load cycle, so the stored carry and the
// neighbour's sum count as zero in that cycle.
module spm_column_cell
    import spm_pkg::*;
#(
    parameter bit HOLD_SUM = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pp,
    input  logic sum_above,
    output logic sum_d,
    output logic sum_q
);
    logic carry_q;
    fa_t  res;

    // Column addition; stale state is masked on a fresh start.
    always_comb begin
        res   = full_add(pp, sum_above & ~clr, carry_q & ~clr);
        sum_d = res.sum;
    end

    // Store the carry for the next column step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= res.carry;
        end
    end

    generate
        if (HOLD_SUM) begin : g_sum_reg
            logic s_q;
            // Store the sum for the column below.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_q <= 1'b0;
                end else begin
                    s_q <= res.sum;
                end
            end
            assign sum_q = s_q;
        end else begin : g_no_sum_reg
            assign sum_q = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/spm_serial_negate.sv
// Module: spm_serial_negate
// Serial two's-complement negator with the output flip-flop. When negation
// is selected, bits pass unchanged up to and including the first 1, and
// every later bit is inverted. Otherwise bits pass unchanged.
// Assumes: clr marks the first bit of a new product.
module spm_serial_negate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic negate,
    input  logic raw_bit,
    output logic out_bit
);
    logic seen_q;
    logic seen_use;
    logic out_q;

    // Forget any 1 seen in an earlier product.
    always_comb begin
        seen_use = seen_q & ~clr;
    end

    // Track the first 1 and register the possibly inverted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            seen_q <= seen_use | raw_bit;
            out_q  <= raw_bit ^ (negate & seen_use);
        end
    end

    assign out_bit = out_q;

    // R8: the first-one flag is cleared only by a new start.
    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && seen_q) |=> seen_q);

endmodule

// File: rtl/spm_signed_mult.sv
// Module: spm_signed_mult (top)
// Signed serial-parallel multiplier. A load pulse captures the parallel
// multiplicand together with multiplier bit 0. The remaining multiplier bits
// follow one per clock, LSB first. Product bit k appears on prod_bit after
// k+1 rising edges, starting with the edge that samples load.
// Assumes: MCAND_W >= 2, MPLR_W >= 1.
module spm_signed_mult #(
    parameter int MCAND_W = 8,
    parameter int MPLR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [MCAND_W-1:0] mcand,
    input  logic               mplr_bit,
    output logic               prod_bit
);
    logic [MCAND_W-1:0] mag_use;
    logic               neg_use;
    logic               b_use;
    logic [MCAND_W:0]   sum_reg;
    logic [MCAND_W-1:0] sum_now;

    spm_magnitude #(.WIDTH(MCAND_W)) u_mag (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .value   (mcand),
        .mag_use (mag_use),
        .neg_use (neg_use)
    );

    spm_mplr_feed #(.WIDTH(MPLR_W)) u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .bit_in  (mplr_bit),
        .bit_use (b_use)
    );

    // Nothing sits above the top column.
    assign sum_reg[MCAND_W] = 1'b0;

    generate
        for (genvar i = 0; i < MCAND_W; i++) begin : g_col
            spm_column_cell #(.HOLD_SUM(i != 0)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (load),
                .pp        (mag_use[i] & b_use),
                .sum_above (sum_reg[i+1]),
                .sum_d     (sum_now[i]),
                .sum_q     (sum_reg[i])
            );
        end
    endgenerate

    spm_serial_negate u_neg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .negate  (neg_use),
        .raw_bit (sum_now[0]),
        .out_bit (prod_bit)
    );

    // R6: the first product bit is the AND of the two operand LSBs.
    assert_first_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_bit == $past(mcand[0] & mplr_bit)));

endmodule

// File: tb/test_spm_signed_mult.sv
// Scoreboard bench: the driver pushes the expected product bits, and the
// monitor pops one per cycle and compares it with prod_bit.
module test_spm_signed_mult;
    localparam int M = 8;
    localparam int N = 6;
    localparam int K = M + N;
    localparam int EXTRA = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [M-1:0] mcand = '0;
    logic         mplr_bit = 1'b0;
    logic         prod_bit;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    spm_signed_mult #(.MCAND_W(M), .MPLR_W(N)) i_spm_signed_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .mcand    (mcand),
        .mplr_bit (mplr_bit),
        .prod_bit (prod_bit)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: prod_bit=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compare one expected bit per cycle, away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), prod_bit, exp_q.pop_front());
        end
    end

    // Driver: one product. noisy drives junk where the block must not look.
    task automatic run(input logic signed [M-1:0] a, input logic signed [N-1:0] b,
                       input string tag, input bit noisy);
        longint p;
        p = longint'(a) * longint'(b);
        @(posedge clk); #1;
        load = 1'b1; mcand = a; mplr_bit = b[0];
        @(posedge clk); #1;
        load = 1'b0;
        for (int k = 0; k < K + EXTRA; k++) begin
            exp_q.push_back(p[k]);
            tag_q.push_back(k == 0 ? "R6" : (k >= K ? "R7" : tag));
        end
        for (int i = 1; i < N; i++) begin
            mplr_bit = b[i];
            if (noisy) mcand = M'($urandom);
            @(posedge clk); #1;
        end
        while (exp_q.size() > 0) begin
            if (noisy) begin
                mplr_bit = 1'($urandom);
                mcand = M'($urandom);
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #1999995;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: idle after reset, inputs toggling without load.
        for (int i = 0; i < 6; i++) begin
            mcand = M'($urandom); mplr_bit = 1'($urandom);
            @(negedge clk);
            check("R1", prod_bit, 1'b0);
        end
        run(8'sd3, 6'sd5, "R2", 1'b0);
        run(8'sd105, 6'sd27, "R3", 1'b0);
        run(-8'sd3, 6'sd5, "R5", 1'b0);
        run(8'sd3, -6'sd5, "R3", 1'b0);
        run(-8'sd77, -6'sd19, "R5", 1'b0);
        run(-8'sd128, -6'sd32, "R5", 1'b0);
        run(-8'sd128, 6'sd31, "R5", 1'b0);
        run(8'sd127, -6'sd32, "R3", 1'b0);
        run(8'sd0, -6'sd1, "R3", 1'b0);
        run(-8'sd1, 6'sd0, "R3", 1'b0);
        run(8'sd91, -6'sd13, "R4", 1'b1);
        run(-8'sd55, 6'sd22, "R9", 1'b1);
        // R8: abandon a product midway, then start a clean one.
        @(posedge clk); #1;
        load = 1'b1; mcand = -8'sd128; mplr_bit = 1'b1;
        @(posedge clk); #1;
        load = 1'b0;
        repeat (4) begin
            mplr_bit = 1'b1;
            @(posedge clk); #1;
        end
        run(8'sd37, 6'sd11, "R8", 1'b0);
        for (int i = 0; i < 6; i++) begin
            run(M'($urandom), N'($urandom), "R3", 1'b0);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule